// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block is an SPI master that drives one command at a time into a page-organised serial flash with two on-chip SRAM buffers. The host hands over a command kind, a buffer select, a 16-bit address field and a byte count. The address field holds a page number for page commands and a byte offset inside the buffer for buffer commands. The block derives the opcode and the address bytes from these inputs. It then reads the device status until the device reports ready, and only after that sends the command frame.

Buffer writes take their payload from a valid/ready byte stream. Buffer reads deliver their payload on a second valid/ready byte stream. A producer that holds back write data, or a consumer that holds back `rd_ready`, pauses the serial clock between bytes. Chip select stays low during such a pause, so a stall never corrupts a frame. A one-cycle `done` pulse marks the end of each command.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` is 0, `cmd_ready` is 1, `rd_valid` is 0 and `done` is 0.
- R2: The serial link uses mode 0. SCK idles low whenever chip select is high. MOSI is valid at each SCK rising edge, and MISO is sampled on that edge. Every byte goes out most significant bit first.
- R3: Command kinds on `cmd_op` map to opcodes, with buffer select 0 giving the first value and 1 giving the second:
  - 0, page into buffer: 0x53 or 0x55.
  - 1, buffer read: 0x54 or 0x56.
  - 2, buffer write: 0x84 or 0x87.
  - 3, program with erase: 0x83 or 0x86.
  - 4, program without erase: 0x88 or 0x89.
  - 5 (and the unused codes 6 and 7), page erase: always 0x81.
- R4: Kinds 0, 3, 4 and 5 send four bytes: the opcode, the high byte of the page number shifted left by PAGE_BITS−8 within 16 bits, the low byte of that shifted word, and then 0x00.
- R5: Buffer commands send the opcode, then 0x00, then the offset high byte, then the offset low byte. A buffer read adds one more 0x00 byte before the first data byte is shifted in.
- R6: Before every command frame the block runs status frames. Each status frame is exactly two bytes, 0xD7 followed by a dummy byte. The block repeats them until bit 7 of the returned byte is 1. No command frame starts while the device reports busy.
- R7: Chip select stays high for at least CS_GAP (default 2) system clocks between any two frames. This covers poll-to-poll, poll-to-command and command-to-poll.
- R8: A buffer write sends exactly `cmd_len` payload bytes, in stream order. `wr_ready` is high only inside the command frame, between bytes. SCK stays low while the block waits for `wr_valid`.
- R9: A buffer read delivers exactly `cmd_len` bytes, in the order they were received. While `rd_valid` is 1 and `rd_ready` is 0, `rd_valid` and `rd_data` hold their values. SCK stays low while a byte is waiting to be taken.
- R10: `done` pulses for one clock in the cycle where chip select rises after the last byte of the command frame. `cmd_ready` is 1 only while chip select is high and no command is in progress.
- R11: A buffer command with `cmd_len` 0 ends right after its header, with no payload bytes: 4 bytes for a write, 5 bytes for a read.
- R12: For page erase, `cmd_buf_sel` has no effect on any byte of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted this cycle when both high |
| cmd_op | input | 3 | Command kind, encoded as in R3 |
| cmd_buf_sel | input | 1 | 0 selects buffer 1, 1 selects buffer 2 |
| cmd_addr | input | 16 | Page number or buffer byte offset |
| cmd_len | input | LEN_W | Payload byte count for buffer read or write |
| wr_valid | input | 1 | Write payload byte offered |
| wr_ready | output | 1 | Write payload byte taken when both high |
| wr_data | input | 8 | Write payload byte |
| rd_valid | output | 1 | Read payload byte available |
| rd_ready | input | 1 | Consumer takes the byte when both high |
| rd_data | output | 8 | Read payload byte |
| done | output | 1 | One-cycle end-of-command pulse |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The bench models the flash. The model counts how many status polls the device answers busy, logs every frame byte, and flags any command frame that arrives while the device is still busy.

A sequencer that checked the wrong status bit, or that skipped the CS pulse between frames, would show up as a wrong poll count, a protocol violation, or a chip-select gap that is too short. A wrong address shift, or a missing dummy byte before read data, would show up as wrong header bytes or as read data that is offset by a byte.

Read and write streams run with random stalls, plus lengths of zero and one. A block that kept clocking during back-pressure, or that miscounted the remaining bytes, would return mismatched or extra data. Page erase is run with both buffer selects to confirm its opcode stays fixed.

// File: rtl/flash_seq_pkg.sv
`timescale 1ns/1ps
package flash_seq_pkg;
  localparam int ADDR_W = 16;
  localparam int HDR_N  = 5;

  typedef enum logic [2:0] {
    K_FETCH   = 3'd0,
    K_BREAD   = 3'd1,
    K_BWRITE  = 3'd2,
    K_PROG_ER = 3'd3,
    K_PROG_NE = 3'd4,
    K_ERASE   = 3'd5
  } cmd_kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_GAP, S_POLL, S_HDR, S_WR, S_RD
  } seq_state_e;

  localparam logic [7:0] OPC_STATUS = 8'hD7;
  localparam logic [7:0] OPC_ERASE  = 8'h81;
  localparam int         RDY_BIT    = 7;
endpackage

// File: rtl/flash_spi_byte.sv
`timescale 1ns/1ps
module flash_spi_byte #(
  parameter int SCK_HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       byte_done,
  output logic [7:0] rx
);
  localparam int DW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam logic [DW-1:0] DIV_END = DW'(SCK_HALF - 1);

  logic          active;
  logic [DW-1:0] div_cnt;
  logic [2:0]    bit_cnt;
  logic [7:0]    tx_sh;
  logic [7:0]    rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      div_cnt   <= '0;
      bit_cnt   <= '0;
      tx_sh     <= '0;
      rx_sh     <= '0;
      sck       <= 1'b0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (!active) begin
        if (start) begin
          active  <= 1'b1;
          tx_sh   <= tx;
          div_cnt <= '0;
          bit_cnt <= '0;
          sck     <= 1'b0;
        end
      end else if (div_cnt == DIV_END) begin
        div_cnt <= '0;
        if (!sck) begin
          sck   <= 1'b1;
          rx_sh <= {rx_sh[6:0], miso};
        end else begin
          sck <= 1'b0;
          if (bit_cnt == 3'd7) begin
            active    <= 1'b0;
            byte_done <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt + 3'd1;
            tx_sh   <= {tx_sh[6:0], 1'b0};
          end
        end
      end else begin
        div_cnt <= div_cnt + DW'(1);
      end
    end
  end

  assign mosi = tx_sh[7];
  assign rx   = rx_sh;
endmodule

// File: rtl/flash_hdr_build.sv
`timescale 1ns/1ps
module flash_hdr_build
  import flash_seq_pkg::*;
#(
  parameter int PAGE_BITS = 9
) (
  input  logic [2:0]              kind,
  input  logic                    buf_sel,
  input  logic [ADDR_W-1:0]       addr,
  output logic [HDR_N-1:0][7:0]   hdr,
  output logic [2:0]              hdr_last,
  output logic                    is_rd,
  output logic                    is_wr
);
  localparam int SHIFT = PAGE_BITS - 8;

  logic [ADDR_W-1:0] page_word;
  logic [7:0]        opc;
  logic              buf_cmd;

  assign page_word = addr << SHIFT;

  always_comb begin
    opc     = OPC_ERASE;
    buf_cmd = 1'b0;
    is_rd   = 1'b0;
    is_wr   = 1'b0;
    case (kind)
      K_FETCH:   opc = buf_sel ? 8'h55 : 8'h53;
      K_BREAD:   begin opc = buf_sel ? 8'h56 : 8'h54; buf_cmd = 1'b1; is_rd = 1'b1; end
      K_BWRITE:  begin opc = buf_sel ? 8'h87 : 8'h84; buf_cmd = 1'b1; is_wr = 1'b1; end
      K_PROG_ER: opc = buf_sel ? 8'h86 : 8'h83;
      K_PROG_NE: opc = buf_sel ? 8'h89 : 8'h88;
      default:   opc = OPC_ERASE;
    endcase
  end

  always_comb begin
    hdr    = '0;
    hdr[0] = opc;
    if (buf_cmd) begin
      hdr[1]   = 8'h00;
      hdr[2]   = addr[15:8];
      hdr[3]   = addr[7:0];
      hdr[4]   = 8'h00;
      hdr_last = is_rd ? 3'd4 : 3'd3;
    end else begin
      hdr[1]   = page_word[15:8];
      hdr[2]   = page_word[7:0];
      hdr[3]   = 8'h00;
      hdr_last = 3'd3;
    end
  end
endmodule

// File: rtl/flash_cmd_seq.sv
`timescale 1ns/1ps
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int PAGE_BITS = 9,
  parameter int SCK_HALF  = 2,
  parameter int CS_GAP    = 2,
  parameter int LEN_W     = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic             cmd_buf_sel,
  input  logic [15:0]      cmd_addr,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             done,
  output logic             spi_cs_n,
  output logic             spi_sck,
  output logic             spi_mosi,
  input  logic             spi_miso
);
  localparam int GW = (CS_GAP > 1) ? $clog2(CS_GAP) : 1;
  localparam logic [GW-1:0]    GAP_END = GW'(CS_GAP - 1);
  localparam logic [LEN_W-1:0] ONE     = LEN_W'(1);

  seq_state_e state, gap_next;
  logic [GW-1:0]            gap_cnt;
  logic [2:0]               idx;
  logic                     poll_ph;
  logic                     wait_byte;
  logic [LEN_W-1:0]         rem;
  logic [HDR_N-1:0][7:0]    hdr_q;
  logic [2:0]               last_q;
  logic                     rd_q, wr_q;
  logic [7:0]               rd_data_q;
  logic                     rd_valid_q;

  logic [HDR_N-1:0][7:0]    hdr_c;
  logic [2:0]               last_c;
  logic                     rd_c, wr_c;

  logic       sp_start, sp_done;
  logic [7:0] sp_tx, sp_rx;

  flash_hdr_build #(.PAGE_BITS(PAGE_BITS)) u_hdr (
    .kind     (cmd_op),
    .buf_sel  (cmd_buf_sel),
    .addr     (cmd_addr),
    .hdr      (hdr_c),
    .hdr_last (last_c),
    .is_rd    (rd_c),
    .is_wr    (wr_c)
  );

  flash_spi_byte #(.SCK_HALF(SCK_HALF)) u_byte (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (sp_start),
    .tx        (sp_tx),
    .miso      (spi_miso),
    .sck       (spi_sck),
    .mosi      (spi_mosi),
    .byte_done (sp_done),
    .rx        (sp_rx)
  );

  always_comb begin
    sp_start = 1'b0;
    sp_tx    = 8'h00;
    case (state)
      S_POLL: if (!wait_byte) begin
        sp_start = 1'b1;
        sp_tx    = poll_ph ? 8'h00 : OPC_STATUS;
      end
      S_HDR: if (!wait_byte) begin
        sp_start = 1'b1;
        sp_tx    = hdr_q[idx];
      end
      S_WR: if (!wait_byte && wr_valid) begin
        sp_start = 1'b1;
        sp_tx    = wr_data;
      end
      S_RD: if (!wait_byte && !rd_valid_q) begin
        sp_start = 1'b1;
      end
      default: ;
    endcase
  end

  assign cmd_ready = (state == S_IDLE);
  assign wr_ready  = (state == S_WR) && !wait_byte;
  assign rd_valid  = rd_valid_q;
  assign rd_data   = rd_data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      gap_next   <= S_POLL;
      gap_cnt    <= '0;
      idx        <= '0;
      poll_ph    <= 1'b0;
      wait_byte  <= 1'b0;
      rem        <= '0;
      hdr_q      <= '0;
      last_q     <= '0;
      rd_q       <= 1'b0;
      wr_q       <= 1'b0;
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
      done       <= 1'b0;
      spi_cs_n   <= 1'b1;
    end else begin
      done <= 1'b0;
      if (sp_start)     wait_byte <= 1'b1;
      else if (sp_done) wait_byte <= 1'b0;

      case (state)
        S_IDLE: if (cmd_valid) begin
          hdr_q    <= hdr_c;
          last_q   <= last_c;
          rd_q     <= rd_c;
          wr_q     <= wr_c;
          rem      <= cmd_len;
          gap_cnt  <= '0;
          gap_next <= S_POLL;
          poll_ph  <= 1'b0;
          state    <= S_GAP;
        end
        S_GAP: begin
          if (gap_cnt == GAP_END) begin
            spi_cs_n <= 1'b0;
            state    <= gap_next;
          end else begin
            gap_cnt <= gap_cnt + GW'(1);
          end
        end
        S_POLL: if (sp_done) begin
          if (!poll_ph) begin
            poll_ph <= 1'b1;
          end else begin
            poll_ph  <= 1'b0;
            idx      <= '0;
            gap_cnt  <= '0;
            spi_cs_n <= 1'b1;
            gap_next <= sp_rx[RDY_BIT] ? S_HDR : S_POLL;
            state    <= S_GAP;
          end
        end
        S_HDR: if (sp_done) begin
          if (idx == last_q) begin
            if (!(rd_q || wr_q) || rem == '0) begin
              spi_cs_n <= 1'b1;
              done     <= 1'b1;
              state    <= S_IDLE;
            end else begin
              state <= rd_q ? S_RD : S_WR;
            end
          end else begin
            idx <= idx + 3'd1;
          end
        end
        S_WR: if (sp_done) begin
          rem <= rem - ONE;
          if (rem == ONE) begin
            spi_cs_n <= 1'b1;
            done     <= 1'b1;
            state    <= S_IDLE;
          end
        end
        S_RD: begin
          if (sp_done) begin
            rd_data_q  <= sp_rx;
            rd_valid_q <= 1'b1;
          end else if (rd_valid_q && rd_ready) begin
            rd_valid_q <= 1'b0;
            rem        <= rem - ONE;
            if (rem == ONE) begin
              spi_cs_n <= 1'b1;
              done     <= 1'b1;
              state    <= S_IDLE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_seq_checker.sv
`timescale 1ns/1ps
module flash_cmd_seq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_ready,
  input logic       wr_ready,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic       done,
  input logic       spi_cs_n,
  input logic       spi_sck
);
  AST_SCK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck); // R2
  AST_CS_MIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |=> spi_cs_n); // R7
  AST_WR_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (!spi_cs_n && !spi_sck)); // R8
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R9
  AST_RD_NO_SCK: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !spi_sck); // R9
  AST_DONE_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(spi_cs_n)); // R10
  AST_READY_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> spi_cs_n); // R10
endmodule

bind flash_cmd_seq flash_cmd_seq_checker u_chk (.*);

// File: tb/flash_cmd_seq_bench.sv
`timescale 1ns/1ps
module flash_cmd_seq_bench;
  localparam int PB    = 10;
  localparam int LEN_W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic             cmd_valid = 1'b0, cmd_ready, cmd_buf_sel = 1'b0;
  logic [2:0]       cmd_op = '0;
  logic [15:0]      cmd_addr = '0;
  logic [LEN_W-1:0] cmd_len = '0;
  logic             wr_valid = 1'b0, wr_ready;
  logic [7:0]       wr_data = '0;
  logic             rd_valid, rd_ready = 1'b0;
  logic [7:0]       rd_data;
  logic             done, spi_cs_n, spi_sck, spi_mosi;
  logic             spi_miso = 1'b0;

  flash_cmd_seq #(.PAGE_BITS(PB), .SCK_HALF(2), .CS_GAP(2), .LEN_W(LEN_W)) u_flash_cmd_seq (.*);

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- flash model ----------------
  logic [7:0] fb [0:63];
  logic [7:0] cf [0:63];
  logic [7:0] shin;
  int nbits = 0, cf_len = 0, busy_cnt = 0, status_frames = 0;
  int bad_status = 0, viol = 0, cmd_frames = 0;

  function automatic logic [7:0] pat(input logic [7:0] opc, input int x);
    return 8'(x * 13) + 8'(x >> 8) + ((opc == 8'h56) ? 8'h5A : 8'h00);
  endfunction

  function automatic logic resp_bit(input int n);
    int idx = n / 8;
    logic [7:0] r = 8'h00;
    if (idx == 1 && fb[0] == 8'hD7) r = (busy_cnt > 0) ? 8'h24 : 8'hA4;
    if ((fb[0] == 8'h54 || fb[0] == 8'h56) && idx >= 5)
      r = pat(fb[0], int'({fb[2], fb[3]}) + idx - 5);
    return r[7 - (n % 8)];
  endfunction

  always @(negedge spi_cs_n) begin
    nbits = 0;
    fb[0] = 8'h00;
    spi_miso = resp_bit(0);
  end

  always @(posedge spi_sck) if (!spi_cs_n) begin
    shin = {shin[6:0], spi_mosi};
    nbits++;
    if (nbits % 8 == 0 && nbits <= 512) fb[nbits/8 - 1] = shin;
    spi_miso = resp_bit(nbits);
  end

  always @(posedge spi_cs_n) if (nbits > 0) begin
    if (fb[0] == 8'hD7) begin
      status_frames++;
      if (nbits != 16) bad_status++;
      if (busy_cnt > 0) busy_cnt--;
    end else begin
      if (busy_cnt != 0) viol++;
      cmd_frames++;
      cf_len = nbits / 8;
      for (int i = 0; i < 64; i++) cf[i] = fb[i];
    end
  end

  // CS high width monitor
  int hi_run = 100;
  always @(negedge clk) begin
    if (spi_cs_n) hi_run++;
    else begin
      if (hi_run > 0 && hi_run < 2) check(0, "R7 cs high width", hi_run, 2);
      hi_run = 0;
    end
  end

  // ---------------- expected model ----------------
  function automatic logic [7:0] exp_opc(input int op, input bit sel);
    case (op)
      0: return sel ? 8'h55 : 8'h53;
      1: return sel ? 8'h56 : 8'h54;
      2: return sel ? 8'h87 : 8'h84;
      3: return sel ? 8'h86 : 8'h83;
      4: return sel ? 8'h89 : 8'h88;
      default: return 8'h81;
    endcase
  endfunction

  function automatic logic [7:0] exp_hdr(input int op, input bit sel, input logic [15:0] a, input int i);
    logic [15:0] w = a << (PB - 8);
    if (i == 0) return exp_opc(op, sel);
    if (op == 1 || op == 2) begin
      if (i == 2) return a[15:8];
      if (i == 3) return a[7:0];
      return 8'h00;
    end
    if (i == 1) return w[15:8];
    if (i == 2) return w[7:0];
    return 8'h00;
  endfunction

  logic [7:0] wq [0:63];
  logic [7:0] rq [0:63];

  task automatic run_cmd(input int op, input bit sel, input logic [15:0] a, input int len,
                         input int busy, input int stall);
    int hl, exp_len, rcnt, st0, cf0;
    bit got_done, cs_at_done;
    hl = (op == 1) ? 5 : 4;
    exp_len = (op == 1 || op == 2) ? hl + len : hl;
    for (int i = 0; i < 64; i++) wq[i] = 8'($urandom);
    busy_cnt = busy;
    st0 = status_frames;
    cf0 = cmd_frames;
    viol = 0;
    bad_status = 0;
    rcnt = 0;
    got_done = 0;
    cs_at_done = 0;
    @(negedge clk);
    cmd_valid = 1; cmd_op = 3'(op); cmd_buf_sel = sel; cmd_addr = a; cmd_len = LEN_W'(len);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
    fork
      if (op == 2) begin
        for (int i = 0; i < len; i++) begin
          wr_valid = 0;
          repeat ($urandom % (stall + 1)) @(negedge clk);
          wr_valid = 1; wr_data = wq[i];
          while (!wr_ready) @(negedge clk);
          @(negedge clk);
        end
        wr_valid = 0;
      end
      if (op == 1) begin
        while (rcnt < len) begin
          @(negedge clk);
          rd_ready = (stall == 0) || ($urandom % 3 == 0);
          if (rd_valid && rd_ready) begin
            rq[rcnt] = rd_data;
            rcnt++;
          end
        end
        @(negedge clk);
        rd_ready = 0;
      end
      begin
        while (!done) @(negedge clk);
        got_done = 1;
        cs_at_done = spi_cs_n;
        @(negedge clk);
        check(!done, "R10 done single cycle", done, 0);
        check(cmd_ready == 1, "R10 ready after done", cmd_ready, 1);
      end
    join
    check(got_done && cs_at_done, "R10 done with cs high", cs_at_done, 1);
    check(status_frames - st0 == busy + 1, "R6 poll count", status_frames - st0, busy + 1);
    check(viol == 0, "R6 command while busy", viol, 0);
    check(bad_status == 0, "R6 status frame length", bad_status, 0);
    check(cmd_frames - cf0 == 1, "R6 one command frame", cmd_frames - cf0, 1);
    check(cf_len == exp_len, (len == 0) ? "R11 frame length" : "R5 frame length", cf_len, exp_len);
    for (int i = 0; i < hl && i < cf_len; i++)
      check(cf[i] == exp_hdr(op, sel, a, i),
            (i == 0) ? ((op >= 5) ? "R12 opcode" : "R3 opcode") : ((op == 1 || op == 2) ? "R5 header" : "R4 page bytes"),
            cf[i], exp_hdr(op, sel, a, i));
    if (op == 2)
      for (int i = 0; i < len && hl + i < cf_len; i++)
        check(cf[hl + i] == wq[i], "R8 write payload", cf[hl + i], wq[i]);
    if (op == 1) begin
      check(rcnt == len, "R9 read count", rcnt, len);
      for (int i = 0; i < len; i++)
        check(rq[i] == pat(exp_opc(1, sel), int'(a) + i), "R9 read payload", rq[i], pat(exp_opc(1, sel), int'(a) + i));
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(spi_cs_n == 1, "R1 cs_n", spi_cs_n, 1);
    check(spi_sck == 0, "R1 sck", spi_sck, 0);
    check(cmd_ready == 1, "R1 cmd_ready", cmd_ready, 1);
    check(rd_valid == 0 && done == 0, "R1 rd_valid/done", {rd_valid, done}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // directed corners
    run_cmd(0, 0, 16'h0123, 0, 0, 0);   // R4 page fetch, shift by 2
    run_cmd(0, 1, 16'h3FFF, 0, 2, 0);   // R4 top page, R6 two busy polls
    run_cmd(3, 1, 16'h0001, 0, 0, 0);   // R3
    run_cmd(4, 0, 16'h0200, 0, 1, 0);   // R3
    run_cmd(5, 0, 16'h00A5, 0, 0, 0);   // R12
    run_cmd(5, 1, 16'h00A5, 0, 3, 0);   // R12 buffer select ignored
    run_cmd(2, 0, 16'h0107, 1, 0, 0);   // R8 single byte
    run_cmd(2, 1, 16'h0010, 8, 1, 3);   // R8 stalls
    run_cmd(2, 0, 16'h0000, 0, 0, 0);   // R11 empty write
    run_cmd(1, 0, 16'h0005, 0, 0, 0);   // R11 empty read
    run_cmd(1, 1, 16'h00FE, 1, 0, 0);   // R5 read extra dummy
    run_cmd(1, 0, 16'h0100, 10, 2, 1);  // R9 back-pressure
    // constrained random
    for (int k = 0; k < 24; k++) begin
      int op = $urandom % 8;
      int ln = (op == 1 || op == 2) ? ($urandom % 13) : 0;
      run_cmd(op, 1'($urandom), 16'($urandom % 1024), ln, $urandom % 4, $urandom % 3);
    end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule